// File: doc/BRIEF.md
# Eight-word pipelined odd-even merge sorter

This block takes a vector of eight unsigned words and returns the same words in ascending order. It is a fixed sorting network, not a sequential sorter. Its first comparator level sorts adjacent pairs. The next two levels merge those pairs into sorted groups of four. The last three levels merge the two groups of four into one sorted group of eight.

Every comparator level is a rank of ascending compare-and-exchange cells followed by a register. A new vector can enter on every clock. Each result leaves a fixed number of cycles after it went in. A valid flag travels alongside the data, so empty slots in the input stream stay empty at the output.

Lane k of a packed vector sits in bits `[k*WORD_W +: WORD_W]`. At the output, lane 0 holds the smallest word and lane 7 the largest.

Top module: `oem_sorter8`

## Requirements
- R1: Whenever `out_valid` is high, each output lane is less than or equal to the lane above it: lane k ≤ lane k+1 for k = 0..6, with lane k in bits `[k*WORD_W +: WORD_W]`.
- R2: The output vector equals the input vector sorted in ascending order. It is a permutation of the input, whatever the input order, including inputs that are already ascending and inputs in fully reversed order.
- R3: `out_valid` equals the value `in_valid` had exactly 6 clock edges earlier. A cycle with `in_valid` low produces a cycle with `out_valid` low.
- R4: The block accepts a vector on every clock. Back-to-back valid vectors each yield their own sorted result, on consecutive cycles, with no interference between them.
- R5: While `rst_n` is low at a clock edge, the following cycle shows `out_valid` low and `out_words` all zero.
- R6: Repeated values survive sorting. Each value appears at the output as many times as it appeared at the input, including when all eight words are equal.
- R7: Words are compared as unsigned numbers, so a word with its top bit set sorts above every word with its top bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_words` as a vector to sort |
| in_words | input | 8*WORD_W | Eight unsigned words; lane k in bits `[k*WORD_W +: WORD_W]` |
| out_valid | output | 1 | Marks `out_words` as a sorted result |
| out_words | output | 8*WORD_W | Ascending result; lane 0 smallest |

## Verification
The bench builds the sorter with `WORD_W` = 8. At that width random vectors often contain repeated values, which exercises R6 without special stimulus. Random draws also regularly land on 0, 0x7F, 0x80 and 0xFF, the edges that matter for unsigned ordering.

With only 256 possible values per lane, the directed cases can write every extreme out literally: reversed input, already ascending input, all lanes equal, and words on both sides of the top bit. A burst of back-to-back vectors and a random stream with gaps then exercise the per-cycle throughput and the alignment of the valid flag.

// File: rtl/oemsort_pkg.sv
// Shared constants and wiring function for the eight-lane odd-even merge sorter.
// Assumes lane count 8; the level table below is written for that size only.
package oemsort_pkg;
    localparam int LANES  = 8;
    localparam int LEVELS = 6;

    // Returns the lane that 'lane' is compared against at level 'lvl';
    // returns 'lane' itself when the lane passes straight through.
    function automatic int partner_of(input int lvl, input int lane);
        int p;
        p = lane;
        case (lvl)
            // pairs of two
            0: p = lane ^ 1;
            // merge to four: outer pairs
            1: p = lane ^ 2;
            // merge to four: middle pair of each group
            2: begin
                if ((lane % 4) == 1)      p = lane + 1;
                else if ((lane % 4) == 2) p = lane - 1;
            end
            // merge to eight: halves against each other
            3: p = lane ^ 4;
            // merge to eight: inner cross pairs
            4: begin
                if (lane == 2 || lane == 3)      p = lane + 2;
                else if (lane == 4 || lane == 5) p = lane - 2;
            end
            // merge to eight: final neighbour fix-up
            5: begin
                if (lane > 0 && lane < LANES - 1)
                    p = ((lane % 2) == 1) ? lane + 1 : lane - 1;
            end
            default: p = lane;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/oem_cas.sv
// Ascending compare-and-exchange cell: lo_o gets the smaller word, hi_o the larger.
// Assumes unsigned operands; purely combinational.
module oem_cas #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] lo_o,
    output logic [WORD_W-1:0] hi_o
);
    logic swap;

    // decide whether the pair is out of order
    assign swap = (a_i > b_i);
    // route the smaller and larger word
    assign lo_o = swap ? b_i : a_i;
    assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/oem_stage.sv
// One comparator level of the network plus its pipeline register.
// LVL selects the wiring from oemsort_pkg::partner_of; unpaired lanes pass through.
module oem_stage
    import oemsort_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LVL    = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vld_i,
    input  logic [LANES-1:0][WORD_W-1:0] dat_i,
    output logic                         vld_o,
    output logic [LANES-1:0][WORD_W-1:0] dat_o
);
    logic [WORD_W-1:0] nxt [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int P = partner_of(LVL, i);
        if (P > i) begin : g_pair
            // one cell per pair, owned by the lower lane
            oem_cas #(.WORD_W(WORD_W)) u_cas (
                .a_i  (dat_i[i]),
                .b_i  (dat_i[P]),
                .lo_o (nxt[i]),
                .hi_o (nxt[P])
            );
        end else if (P == i) begin : g_pass
            // lane not compared at this level
            assign nxt[i] = dat_i[i];
        end
    end

    // register the level result and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            dat_o <= '0;
        end else begin
            vld_o <= vld_i;
            for (int k = 0; k < LANES; k++) dat_o[k] <= nxt[k];
        end
    end
endmodule

// File: rtl/oem_sorter8.sv
// Top: eight-word ascending sorter built from odd-even merges (2, 4, then 8 wide),
// six registered comparator levels, one vector accepted per clock.
// Assumes unsigned words; lane k occupies bits [k*WORD_W +: WORD_W].
module oem_sorter8
    import oemsort_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*WORD_W-1:0]   in_words,
    output logic                      out_valid,
    output logic [LANES*WORD_W-1:0]   out_words
);
    logic [LANES-1:0][WORD_W-1:0] lvl_dat [LEVELS+1];
    logic                         lvl_vld [LEVELS+1];

    // feed the first level
    assign lvl_dat[0] = in_words;
    assign lvl_vld[0] = in_valid;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        // one registered comparator level
        oem_stage #(.WORD_W(WORD_W), .LVL(l)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (lvl_vld[l]),
            .dat_i (lvl_dat[l]),
            .vld_o (lvl_vld[l+1]),
            .dat_o (lvl_dat[l+1])
        );
    end

    // drive the outputs from the last level
    assign out_words = lvl_dat[LEVELS];
    assign out_valid = lvl_vld[LEVELS];
endmodule

// File: rtl/oem_sorter8_chk.sv
// Property checker for oem_sorter8, attached by bind below.
// Tracks input valid and input word sums independently of the datapath.
module oem_sorter8_chk
    import oemsort_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LANES*WORD_W-1:0] in_words,
    input logic                    out_valid,
    input logic [LANES*WORD_W-1:0] out_words
);
    localparam int SUM_W = WORD_W + 3;

    logic [LEVELS-1:0] vld_hist;
    logic [SUM_W-1:0]  sum_hist [LEVELS];
    logic [SUM_W-1:0]  in_sum;
    logic [SUM_W-1:0]  out_sum;
    logic              out_sorted;

    // add up the input and output words, and test output ordering
    always_comb begin
        in_sum     = '0;
        out_sum    = '0;
        out_sorted = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            in_sum  = in_sum  + SUM_W'(in_words[k*WORD_W +: WORD_W]);
            out_sum = out_sum + SUM_W'(out_words[k*WORD_W +: WORD_W]);
        end
        for (int k = 0; k < LANES - 1; k++)
            if (out_words[k*WORD_W +: WORD_W] > out_words[(k+1)*WORD_W +: WORD_W])
                out_sorted = 1'b0;
    end

    // delay line of valid flags and sums matching the pipeline depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_hist <= '0;
            for (int k = 0; k < LEVELS; k++) sum_hist[k] <= '0;
        end else begin
            vld_hist <= {vld_hist[LEVELS-2:0], in_valid};
            sum_hist[0] <= in_sum;
            for (int k = 1; k < LEVELS; k++) sum_hist[k] <= sum_hist[k-1];
        end
    end

    // R1
    ordered_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sorted);

    // R2
    sum_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum == sum_hist[LEVELS-1]));

    // R3
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_hist[LEVELS-1]);

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_words == '0));
endmodule

bind oem_sorter8 oem_sorter8_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_words  (in_words),
    .out_valid (out_valid),
    .out_words (out_words)
);

// File: tb/tb_oem_sorter8.sv
// Self-checking bench for oem_sorter8: directed corner vectors plus seeded random stream.
module tb_oem_sorter8;
    localparam int W   = 8;
    localparam int N   = 8;
    localparam int LAT = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_words = '0;
    wire            out_valid;
    wire  [N*W-1:0] out_words;

    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    done   = 1'b0;
    logic           hv [8];
    logic [N*W-1:0] hw [8];
    string          ht [8];

    // 50 MHz clock
    always #10 clk = ~clk;

    oem_sorter8 #(.WORD_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_words  (in_words),
        .out_valid (out_valid),
        .out_words (out_words)
    );

    // reference ascending sort by insertion
    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [W-1:0] t;
        logic [N*W-1:0] r;
        for (int k = 0; k < N; k++) a[k] = v[k*W +: W];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0; j--) begin
                if (a[j-1] > a[j]) begin
                    t = a[j]; a[j] = a[j-1]; a[j-1] = t;
                end
            end
        end
        r = '0;
        for (int k = 0; k < N; k++) r[k*W +: W] = a[k];
        return r;
    endfunction

    // lane-by-lane ascending test on an observed vector
    function automatic bit is_asc(input logic [N*W-1:0] v);
        for (int k = 0; k < N - 1; k++)
            if (v[k*W +: W] > v[(k+1)*W +: W]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string req, input bit ok,
                         input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // at a falling edge: check the slot issued LAT cycles ago, then drive a new one
    task automatic step(input bit v, input logic [N*W-1:0] w, input string tag);
        int idx;
        logic [N*W-1:0] exp;
        if (cyc >= LAT) begin
            idx = (cyc - LAT) % 8;
            check("R3", out_valid == hv[idx], {63'b0, out_valid}, {63'b0, hv[idx]});
            if (hv[idx]) begin
                exp = ref_sort(hw[idx]);
                check(ht[idx], out_words == exp, out_words, exp);
                check("R1", is_asc(out_words), out_words, exp);
            end
        end else begin
            check("R5", out_valid == 1'b0, {63'b0, out_valid}, '0);
        end
        in_valid = v;
        in_words = w;
        hv[cyc % 8] = v;
        hw[cyc % 8] = w;
        ht[cyc % 8] = tag;
        cyc++;
        @(negedge clk);
    endtask

    function automatic logic [N*W-1:0] rnd_vec();
        return {$urandom, $urandom};
    endfunction

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int k = 0; k < 8; k++) begin
            hv[k] = 1'b0; hw[k] = '0; ht[k] = "R2";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: outputs cleared while in reset
        check("R5", out_valid == 1'b0, {63'b0, out_valid}, '0);
        check("R5", out_words == '0, out_words, '0);
        rst_n = 1'b1;

        // R2: fully reversed input (lane 0 largest)
        step(1'b1, 64'h01_02_03_04_05_06_07_08, "R2");
        step(1'b0, '0, "R2");
        // R2: already ascending input
        step(1'b1, 64'h80_70_60_50_40_30_20_10, "R2");
        step(1'b0, '0, "R2");
        // R6: all lanes equal, then repeated values
        step(1'b1, 64'h5A_5A_5A_5A_5A_5A_5A_5A, "R6");
        step(1'b1, 64'h03_01_03_01_02_02_03_01, "R6");
        // R7: words on both sides of the top bit
        step(1'b1, 64'h00_FF_80_7F_01_FE_81_00, "R7");
        step(1'b1, 64'h7F_80_7F_80_7F_80_7F_80, "R7");
        // R2: reversed with extremes
        step(1'b1, 64'h00_10_20_7F_80_C0_E0_FF, "R2");
        // R4: back-to-back burst
        for (int b = 0; b < 16; b++) step(1'b1, rnd_vec(), "R4");
        // random stream with gaps
        for (int r = 0; r < 300; r++) step(($urandom % 4) != 0, rnd_vec(), "R2");
        // drain
        for (int d = 0; d < 8; d++) step(1'b0, '0, "R3");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule